// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block is one copy channel sitting between a host and a shared word-wide memory. The host manages two rings of descriptors in that memory. It queues source descriptors on one ring and posts empty receive buffers on the other. It then tells the engine how far it has filled each ring by writing a producer index. Whenever both rings have outstanding entries, the engine does the following: it takes the next receive buffer, copies one source buffer into it, or several chained source buffers back to back, writes the received length and flags into that receive descriptor, and only then moves its consumer indices forward.

Completion is visible in three ways. The receive descriptor's length field stops being zero. The consumer index moves. A copy-complete status bit sets, and it drives the interrupt line when its enable is on. Occupancy thresholds on each ring give watermark status as well. All configuration, indices and status go through a small register port.

Top module: `ce_desc_engine`

## Requirements
- R1: After reset, both producer indices and both consumer indices read 0. The interrupt enable register (offset 6) and the status register (offset 7) read 0, and `irq` is low.
- R2: A descriptor is two memory words at ring base + 2 × index. Word 0 holds the buffer word address. Word 1 holds the byte count in bits [15:0] and the flags in bits [31:16]. Flag bit 0 marks a chained (gather) entry, flag bit 1 requests byte reversal, and flag bits [15:2] carry a transfer tag.
- R3: A non-chained transfer of n bytes copies ceil(n/4) consecutive words from the source buffer to the receive buffer and leaves later receive words untouched. Each consumer index then advances by one, modulo the ring size; the ring size is a power of two.
- R4: The count field of control register offset 5, bits [15:0], caps the bytes taken from any one source descriptor. Its reset value is 0xFFFF.
- R5: Source entries with the gather bit set, followed by one entry without it, are packed into one receive buffer in ring order. The written-back length is their sum, and the receive consumer index advances once. If a chained entry is not yet followed by another queued entry, the engine waits without completing.
- R6: Receive word 1 is written as {tag, swap bit, gather bit = 0, total length}, taking tag and swap from the final source entry. This write happens before the receive consumer index moves. A posted receive entry keeps its zero length until then, and nothing starts while either ring is empty.
- R7: Each copied word has its bytes reversed when the entry's swap flag is set and at least one of the control bits 16 (source side) or 17 (receive side) is set. Otherwise the word is copied unchanged.
- R8: Status bit 0 sets on every completion. Writing ones to offset 7 clears those bits. `irq` is high one cycle after any status bit whose enable (same bit of offset 6) is set.
- R9: The watermark register (offset 4 or 12) holds the low mark in [7:0] and the high mark in [15:8]. When occupancy rises above the high mark, status bit 1 (source) or 3 (receive) sets. When occupancy falls below the low mark, status bit 2 or 4 sets.
- R10: Writes to a ring's base or size register are ignored while that ring's producer and consumer indices differ.
- R11: The source ring uses base 0, size 1, producer 2, consumer 3 (read-only) and watermark 4. The receive ring uses the same layout at 8 to 12. Size reads back as the entry count, and register reads return data on the cycle after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_re` |
| irq | output | 1 | Level interrupt |

## Verification
Register reads land one cycle after the strobe, and `irq` follows a status or enable change by one further cycle. The bench therefore waits two falling edges after such a write before it samples. A transfer of w words needs 8 + 2w cycles once both rings hold work, so the bench never predicts that cycle. It polls the receive consumer index through the register port and inspects memory only after the index has moved. Negative checks on the gather wait and the zero-length sentinel allow a fixed 60-cycle window, which is far longer than any single transfer.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam logic [3:0] REG_BASE  = 4'd0;
  localparam logic [3:0] REG_SIZE  = 4'd1;
  localparam logic [3:0] REG_WR    = 4'd2;
  localparam logic [3:0] REG_RD    = 4'd3;
  localparam logic [3:0] REG_WM    = 4'd4;
  localparam logic [3:0] REG_CTRL  = 4'd5;
  localparam logic [3:0] REG_IEN   = 4'd6;
  localparam logic [3:0] REG_ISTAT = 4'd7;
  localparam int RING_STRIDE = 8;
  localparam int FLG_GATHER = 0;
  localparam int FLG_SWAP   = 1;
  localparam int NSTAT      = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DADDR, ST_SADDR, ST_SMETA, ST_LEN,
    ST_RD, ST_WR, ST_NEXT, ST_GWAIT, ST_WB, ST_FIN
  } ce_state_t;

  function automatic logic [31:0] rev_bytes(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/ce_ring_ctl.sv
module ce_ring_ctl #(
  parameter int AW = 12,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_base,
  input  logic          we_size,
  input  logic          we_wr,
  input  logic          we_wm,
  input  logic [31:0]   wdata,
  input  logic          adv,
  output logic [AW-1:0] base,
  output logic [IW-1:0] mask,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic [15:0]   wm,
  output logic          pending,
  output logic          hi_ev,
  output logic          lo_ev
);
  logic [IW-1:0] hi_m, lo_m, occ, occ_q;

  assign pending = (wr_idx != rd_idx);
  assign occ     = (wr_idx - rd_idx) & mask;
  assign wm      = {8'(hi_m), 8'(lo_m)};

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      mask   <= '1;
      wr_idx <= '0;
      rd_idx <= '0;
      hi_m   <= '1;
      lo_m   <= '0;
      occ_q  <= '0;
      hi_ev  <= 1'b0;
      lo_ev  <= 1'b0;
    end else begin
      if (we_base && !pending) base <= wdata[AW-1:0];
      if (we_size && !pending) mask <= IW'(wdata[IW-1:0] - IW'(1));
      if (we_wr) wr_idx <= wdata[IW-1:0] & mask;
      if (adv) rd_idx <= (rd_idx + IW'(1)) & mask;
      if (we_wm) begin
        lo_m <= wdata[IW-1:0];
        hi_m <= wdata[8+IW-1:8];
      end
      occ_q <= occ;
      hi_ev <= (occ > hi_m) && (occ_q <= hi_m);
      lo_ev <= (occ < lo_m) && (occ_q >= lo_m);
    end
  end
endmodule

// File: rtl/ce_desc_engine.sv
module ce_desc_engine
  import ce_pkg::*;
#(
  parameter int AW = 12,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int NR  = 2;
  localparam int WCW = 15;

  logic [NR-1:0] we_base, we_size, we_wr, we_wm, adv, pend, hi_ev, lo_ev;
  logic [NR-1:0][AW-1:0] base;
  logic [NR-1:0][IW-1:0] mask, wr_idx, rd_idx;
  logic [NR-1:0][15:0]   wm;

  for (genvar g = 0; g < NR; g++) begin : g_ring
    localparam logic [3:0] OFS = 4'(RING_STRIDE * g);
    assign we_base[g] = reg_we && (reg_addr == OFS + REG_BASE);
    assign we_size[g] = reg_we && (reg_addr == OFS + REG_SIZE);
    assign we_wr[g]   = reg_we && (reg_addr == OFS + REG_WR);
    assign we_wm[g]   = reg_we && (reg_addr == OFS + REG_WM);
    ce_ring_ctl #(.AW(AW), .IW(IW)) u_ring (
      .clk(clk), .rst(rst), .we_base(we_base[g]), .we_size(we_size[g]),
      .we_wr(we_wr[g]), .we_wm(we_wm[g]), .wdata(reg_wdata), .adv(adv[g]),
      .base(base[g]), .mask(mask[g]), .wr_idx(wr_idx[g]), .rd_idx(rd_idx[g]),
      .wm(wm[g]), .pending(pend[g]), .hi_ev(hi_ev[g]), .lo_ev(lo_ev[g])
    );
  end

  // control, enables, status
  logic [15:0]       dmax;
  logic              src_swap_en, dst_swap_en;
  logic [NSTAT-1:0]  int_en, int_stat, stat_set, stat_clr;
  ce_state_t         st;
  logic [AW-1:0]     sptr, dptr, s_desc, d_desc;
  logic [WCW-1:0]    wcnt, words;
  logic [15:0]       total, flg, take;
  logic              load_dptr, do_swap;

  assign stat_set = {lo_ev[1], hi_ev[1], lo_ev[0], hi_ev[0], st == ST_FIN};
  assign stat_clr = (reg_we && reg_addr == REG_ISTAT) ? reg_wdata[NSTAT-1:0] : '0;
  assign adv      = {st == ST_FIN, st == ST_NEXT};

  always_ff @(posedge clk) begin
    if (rst) begin
      dmax        <= 16'hFFFF;
      src_swap_en <= 1'b0;
      dst_swap_en <= 1'b0;
      int_en      <= '0;
      int_stat    <= '0;
      irq         <= 1'b0;
    end else begin
      if (reg_we && reg_addr == REG_CTRL) begin
        dmax        <= reg_wdata[15:0];
        src_swap_en <= reg_wdata[16];
        dst_swap_en <= reg_wdata[17];
      end
      if (reg_we && reg_addr == REG_IEN) int_en <= reg_wdata[NSTAT-1:0];
      int_stat <= (int_stat & ~stat_clr) | stat_set;
      irq      <= |(int_stat & int_en);
    end
  end

  // register read path
  logic [31:0] rd_mux;
  logic        rsel;
  always_comb begin
    rsel   = reg_addr[3];
    rd_mux = '0;
    case (reg_addr)
      REG_CTRL:  rd_mux = {14'b0, dst_swap_en, src_swap_en, dmax};
      REG_IEN:   rd_mux = 32'(int_en);
      REG_ISTAT: rd_mux = 32'(int_stat);
      default: begin
        case (reg_addr[2:0])
          REG_BASE[2:0]: rd_mux = 32'(base[rsel]);
          REG_SIZE[2:0]: rd_mux = 32'(mask[rsel]) + 32'd1;
          REG_WR[2:0]:   rd_mux = 32'(wr_idx[rsel]);
          REG_RD[2:0]:   rd_mux = 32'(rd_idx[rsel]);
          REG_WM[2:0]:   rd_mux = 32'(wm[rsel]);
          default:       rd_mux = '0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  // descriptor walker
  assign s_desc  = base[0] + AW'({rd_idx[0], 1'b0});
  assign d_desc  = base[1] + AW'({rd_idx[1], 1'b0});
  assign take    = (mem_rdata[15:0] > dmax) ? dmax : mem_rdata[15:0];
  assign words   = WCW'((17'(take) + 17'd3) >> 2);
  assign do_swap = flg[FLG_SWAP] && (src_swap_en || dst_swap_en);

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_DADDR: begin mem_re = 1'b1; mem_addr = d_desc; end
      ST_SADDR: begin mem_re = 1'b1; mem_addr = s_desc; end
      ST_SMETA: begin mem_re = 1'b1; mem_addr = s_desc + AW'(1); end
      ST_RD:    begin mem_re = 1'b1; mem_addr = sptr; end
      ST_WR: begin
        mem_we    = 1'b1;
        mem_addr  = dptr;
        mem_wdata = do_swap ? rev_bytes(mem_rdata) : mem_rdata;
      end
      ST_WB: begin
        mem_we    = 1'b1;
        mem_addr  = d_desc + AW'(1);
        mem_wdata = {flg & ~(16'd1 << FLG_GATHER), total};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sptr      <= '0;
      dptr      <= '0;
      wcnt      <= '0;
      total     <= '0;
      flg       <= '0;
      load_dptr <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (&pend) begin
          st        <= ST_DADDR;
          total     <= '0;
          load_dptr <= 1'b1;
        end
        ST_DADDR: st <= ST_SADDR;
        ST_SADDR: begin
          if (load_dptr) dptr <= mem_rdata[AW-1:0];
          load_dptr <= 1'b0;
          st        <= ST_SMETA;
        end
        ST_SMETA: begin
          sptr <= mem_rdata[AW-1:0];
          st   <= ST_LEN;
        end
        ST_LEN: begin
          flg   <= mem_rdata[31:16];
          total <= total + take;
          wcnt  <= words;
          st    <= (words == '0) ? ST_NEXT : ST_RD;
        end
        ST_RD: st <= ST_WR;
        ST_WR: begin
          sptr <= sptr + AW'(1);
          dptr <= dptr + AW'(1);
          wcnt <= wcnt - WCW'(1);
          st   <= (wcnt == WCW'(1)) ? ST_NEXT : ST_RD;
        end
        ST_NEXT:  st <= flg[FLG_GATHER] ? ST_GWAIT : ST_WB;
        ST_GWAIT: if (pend[0]) st <= ST_SADDR;
        ST_WB:    st <= ST_FIN;
        ST_FIN:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ce_desc_engine_chk.sv
module ce_desc_engine_chk #(
  parameter int AW = 12,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_re,
  input logic          mem_we,
  input logic          irq,
  input logic [4:0]    stat,
  input logic [4:0]    en,
  input logic [IW-1:0] src_rd,
  input logic [IW-1:0] dst_rd,
  input logic [IW-1:0] src_mask,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [AW-1:0] dst_base,
  input logic          dst_pend
);
  // R3
  src_step_chk: assert property (@(posedge clk) disable iff (rst)
    (src_rd != $past(src_rd)) |-> (src_rd == (($past(src_rd) + IW'(1)) & src_mask)));

  // R6
  wb_before_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (dst_rd != $past(dst_rd)) |-> $past(mem_we, 2));

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ($past((stat & en) == 5'd0)) |-> !irq);

  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 4'd8 && dst_pend) |=> $stable(dst_base));

  // R2
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
endmodule

bind ce_desc_engine ce_desc_engine_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .mem_re(mem_re), .mem_we(mem_we), .irq(irq),
  .stat(int_stat), .en(int_en), .src_rd(rd_idx[0]), .dst_rd(rd_idx[1]),
  .src_mask(mask[0]), .reg_we(reg_we), .reg_addr(reg_addr),
  .dst_base(base[1]), .dst_pend(pend[1])
);

// File: tb/ce_desc_engine_test.sv
`timescale 1ns/1ps
module ce_desc_engine_test;
  localparam int SB = 'h10;
  localparam int DB = 'h20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        reg_we = 0, reg_re = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_re, mem_we, irq;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  ce_desc_engine uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  logic [31:0] mem [0:4095];
  logic        tb_we = 0;
  logic [11:0] tb_addr = 0;
  logic [31:0] tb_data = 0;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else if (tb_we) mem[tb_addr] <= tb_data;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int nchk = 0, nfail = 0;
  int swi = 0, dwi = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic regr(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; d = reg_rdata;
  endtask

  task automatic memw(input int a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_addr = 12'(a); tb_data = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic put_src(input int a, input int n, input logic [15:0] f);
    memw(SB + 2*swi, a);
    memw(SB + 2*swi + 1, {f, 16'(n)});
    swi = (swi + 1) & 3;
  endtask

  task automatic put_dst(input int a);
    memw(DB + 2*dwi, a);
    memw(DB + 2*dwi + 1, 0);
    dwi = (dwi + 1) & 3;
  endtask

  task automatic wait_dst(input int target);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      regr(4'd11, v);
      if (v == 32'(target)) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    int slot, w, prev;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    regr(4'd3, v);  chk(v == 0, "R1 src consumer", v, 0);
    regr(4'd11, v); chk(v == 0, "R1 dst consumer", v, 0);
    regr(4'd2, v);  chk(v == 0, "R1 src producer", v, 0);
    regr(4'd6, v);  chk(v == 0, "R1 enables", v, 0);
    regr(4'd7, v);  chk(v == 0, "R1 status", v, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);

    regw(4'd0, SB); regw(4'd1, 4);
    regw(4'd8, DB); regw(4'd9, 4);
    regr(4'd1, v); chk(v == 4, "R11 size readback", v, 4);

    // R3 sweep of lengths, wrapping both rings
    for (int k = 0; k < 9; k++) begin
      int n = k + 1;
      int sa = 'h100 + 16*k;
      int da = 'h200 + 16*k;
      for (int j = 0; j < 4; j++) begin
        memw(sa + j, 32'hA000_0000 + 32'(k*256 + j));
        memw(da + j, 32'hDEAD_0000 + 32'(j));
      end
      slot = dwi;
      put_src(sa, n, 16'((k+1) << 2));
      put_dst(da);
      regw(4'd10, dwi);
      regw(4'd2, swi);
      wait_dst(dwi);
      w = (n + 3) / 4;
      for (int j = 0; j < 4; j++) begin
        e = (j < w) ? 32'hA000_0000 + 32'(k*256 + j) : 32'hDEAD_0000 + 32'(j);
        chk(mem[da + j] == e, "R3 data word", mem[da + j], e);
      end
      e = {16'((k+1) << 2), 16'(n)};
      chk(mem[DB + 2*slot + 1] == e, "R2/R6 writeback", mem[DB + 2*slot + 1], e);
      regr(4'd3, v); chk(v == 32'(swi), "R3 src consumer wrap", v, 32'(swi));
    end

    // R4 length cap
    regw(4'd5, 8);
    for (int j = 0; j < 6; j++) begin
      memw('h180 + j, 32'hC000_0000 + 32'(j));
      memw('h280 + j, 32'hDEAD_0000 + 32'(j));
    end
    slot = dwi;
    put_src('h180, 20, 16'h40);
    put_dst('h280);
    regw(4'd10, dwi); regw(4'd2, swi);
    wait_dst(dwi);
    for (int j = 0; j < 6; j++) begin
      e = (j < 2) ? 32'hC000_0000 + 32'(j) : 32'hDEAD_0000 + 32'(j);
      chk(mem['h280 + j] == e, "R4 capped data", mem['h280 + j], e);
    end
    chk(mem[DB + 2*slot + 1] == {16'h40, 16'd8}, "R4 capped length", mem[DB + 2*slot + 1], {16'h40, 16'd8});
    regw(4'd5, 'hFFFF);

    // R5 gather of three entries into one buffer
    for (int j = 0; j < 3; j++) begin
      memw('h1C0 + j, 32'hB100_0000 + 32'(j));
      memw('h1D0 + j, 32'hB200_0000 + 32'(j));
      memw('h1E0 + j, 32'hB300_0000 + 32'(j));
    end
    for (int j = 0; j < 8; j++) memw('h2C0 + j, 32'hDEAD_0000 + 32'(j));
    prev = dwi;
    slot = dwi;
    put_src('h1C0, 8, 16'h0D);
    put_src('h1D0, 4, 16'h09);
    put_src('h1E0, 12, 16'h14);
    put_dst('h2C0);
    regw(4'd10, dwi);
    regw(4'd2, (swi + 1) & 1 ? ((swi + 2) & 3) : ((swi + 2) & 3));
    repeat (60) @(negedge clk);
    regr(4'd11, v); chk(v == 32'(prev), "R5 waits for chain end", v, 32'(prev));
    chk(mem[DB + 2*slot + 1] == 0, "R6 sentinel stays zero", mem[DB + 2*slot + 1], 0);
    regw(4'd2, swi);
    wait_dst(dwi);
    for (int j = 0; j < 7; j++) begin
      if (j < 2)      e = 32'hB100_0000 + 32'(j);
      else if (j < 3) e = 32'hB200_0000;
      else if (j < 6) e = 32'hB300_0000 + 32'(j - 3);
      else            e = 32'hDEAD_0006;
      chk(mem['h2C0 + j] == e, "R5 gathered data", mem['h2C0 + j], e);
    end
    chk(mem[DB + 2*slot + 1] == {16'h14, 16'd24}, "R5 total length", mem[DB + 2*slot + 1], {16'h14, 16'd24});
    regr(4'd3, v); chk(v == 32'(swi), "R5 src consumer", v, 32'(swi));

    // R7 byte reversal combinations
    for (int c = 0; c < 4; c++) begin
      logic [31:0] d;
      logic [15:0] f;
      bit sw;
      d  = 32'h1122_3340 + 32'(c);
      f  = (c == 2) ? 16'h18 : 16'h1A;
      sw = (c == 0) || (c == 3);
      regw(4'd5, (c == 0) ? 32'h1_FFFF : (c == 1) ? 32'h0_FFFF : 32'h2_FFFF);
      memw('h1A0, d);
      memw('h2A0, 32'hDEAD_0000);
      slot = dwi;
      put_src('h1A0, 4, f);
      put_dst('h2A0);
      regw(4'd10, dwi); regw(4'd2, swi);
      wait_dst(dwi);
      e = sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
      chk(mem['h2A0] == e, "R7 swap data", mem['h2A0], e);
      chk(mem[DB + 2*slot + 1] == {f, 16'd4}, "R6 swap flag returned", mem[DB + 2*slot + 1], {f, 16'd4});
    end
    regw(4'd5, 'hFFFF);

    // R8 interrupt status and enable
    regw(4'd7, 'h1F);
    memw('h1A0, 32'h5555_AAAA);
    put_src('h1A0, 4, 16'h0);
    put_dst('h2A0);
    regw(4'd10, dwi); regw(4'd2, swi);
    wait_dst(dwi);
    regr(4'd7, v); chk(v[0] == 1, "R8 completion status", v, 1);
    chk(irq == 0, "R8 irq masked", 32'(irq), 0);
    regw(4'd6, 1);
    repeat (2) @(negedge clk);
    chk(irq == 1, "R8 irq enabled", 32'(irq), 1);
    regw(4'd7, 1);
    repeat (2) @(negedge clk);
    chk(irq == 0, "R8 irq after clear", 32'(irq), 0);
    regr(4'd7, v); chk(v[0] == 0, "R8 write one clears", v, 0);
    regw(4'd6, 0);

    // R10 base and size writes ignored while pending
    memw('h2E0, 32'hDEAD_0000);
    slot = dwi;
    prev = dwi;
    put_dst('h2E0);
    regw(4'd10, dwi);
    regw(4'd8, 'h300);
    regr(4'd8, v); chk(v == DB, "R10 base held", v, DB);
    regw(4'd9, 2);
    regr(4'd9, v); chk(v == 4, "R10 size held", v, 4);
    repeat (20) @(negedge clk);
    regr(4'd11, v); chk(v == 32'(prev), "R6 no start without source", v, 32'(prev));
    memw('h1F0, 32'h7777_0001);
    put_src('h1F0, 4, 16'h0);
    regw(4'd2, swi);
    wait_dst(dwi);
    chk(mem['h2E0] == 32'h7777_0001, "R10 original base used", mem['h2E0], 32'h7777_0001);
    chk(mem[DB + 2*slot + 1] == {16'h0, 16'd4}, "R10 descriptor done", mem[DB + 2*slot + 1], {16'h0, 16'd4});

    // R9 watermarks on the source ring
    regw(4'd7, 'h1F);
    regw(4'd4, (1 << 8) | 1);
    put_src('h1F0, 4, 16'h0);
    put_src('h1F0, 4, 16'h0);
    regw(4'd2, swi);
    repeat (4) @(negedge clk);
    regr(4'd7, v); chk((v & 6) == 2, "R9 high mark crossed", v & 6, 2);
    put_dst('h2F0);
    put_dst('h2F8);
    regw(4'd10, dwi);
    wait_dst(dwi);
    repeat (4) @(negedge clk);
    regr(4'd7, v); chk((v & 6) == 6, "R9 low mark crossed", v & 6, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule